// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge-Detect Interrupt

This block is a general-purpose I/O controller for 64 pins. The pins are grouped into two banks of 32. Software reaches it over a small 32-bit register bus with one request per cycle. Each pin can be set up as an input or as an output.

Output levels change through two separate words: one sets bits and one clears bits. A driver can therefore change one pin without reading the latch first. Every pin input passes through a two-flop synchroniser. The synchronised value feeds the level read-back and the edge detector.

Each pin can arm rising-edge detection, falling-edge detection, or both. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. One level-type interrupt line is high while any status bit in either bank is set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), every output latch is 0 (`pin_out` all 0), all edge enables are off, all status bits are 0 and `irq` is 0.
- R2: Pin n lives in bank n/32 at bit n%32. The register word at byte address class*8 + bank*4 is selected by `bus_addr`. The classes are numbered: 0 level, 1 direction, 2 set-output, 3 clear-output, 4 rising enable, 5 falling enable, 6 edge status.
- R3: A direction bit of 1 makes the pin an output and drives its `pin_oe` bit to 1. A direction bit of 0 makes the pin an input. The direction word reads back as written.
- R4: Writing 1 to a bit of the set-output word forces that pin's latch (`pin_out`) to 1. Writing 1 to a bit of the clear-output word forces it to 0. Zero bits leave their latches unchanged. Reads of the set-output and clear-output words return 0.
- R5: The level word returns `pin_in` as seen after a two-flop synchroniser. A change on `pin_in` is readable from the third rising clock edge after it onwards.
- R6: When a pin's rising enable is 1, a low-to-high change of its synchronised level sets its status bit. A pin with neither enable set never sets its status bit.
- R7: When a pin's falling enable is 1, a high-to-low change of its synchronised level sets its status bit. A rising change does not set the bit when only the falling enable is set.
- R8: With both enables set, either direction of change sets the status bit.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits are never cleared in any other way.
- R10: If an edge on a pin is detected in the same cycle as a write that clears that pin's status bit, the bit stays set.
- R11: `irq` is a registered output. It is 1 exactly one cycle after any status bit in either bank is 1, and 0 one cycle after all status bits are 0.
- R12: A read request (`bus_valid`=1, `bus_write`=0) returns its data on `bus_rdata` with `bus_rvalid`=1 in the following cycle. A write never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | 64 | Asynchronous pin levels |
| pin_out | output | 64 | Output latches |
| pin_oe | output | 64 | Output enable per pin (direction) |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The collision of interest is an edge capture and a status-clear write landing on the same bit in the same cycle. The bench first arms both edges on a pin and leaves its status bit set from an earlier edge. It then changes the pin level and times the clear-write so that the write occupies the exact clock edge on which the synchronised edge is captured, which is the third edge after the pin change. It judges the result by reading the status word afterwards, where the bit must still be 1 and `irq` must remain high. A second clear without any collision must then bring the bit and `irq` to 0.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // register classes; the word address is class * (banks*4) + bank*4
  typedef enum logic [2:0] {
    CLS_LEVEL = 3'd0,
    CLS_DIR   = 3'd1,
    CLS_SET   = 3'd2,
    CLS_CLR   = 3'd3,
    CLS_RISE  = 3'd4,
    CLS_FALL  = 3'd5,
    CLS_STAT  = 3'd6,
    CLS_NONE  = 3'd7
  } reg_cls_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] lvl_sync,
  output logic [WIDTH-1:0] lvl_prev
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      lvl_sync <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= pin_async;
      lvl_sync <= meta_q;
      lvl_prev <= lvl_sync;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_cls_e         wr_cls,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] lvl_sync,
  input  logic [WIDTH-1:0] lvl_prev,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] rise_q,
  output logic [WIDTH-1:0] fall_q,
  output logic [WIDTH-1:0] stat_q
);
  logic [WIDTH-1:0] hits;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] stat_next;
  logic             stat_wr;

  assign hits      = (rise_q & lvl_sync & ~lvl_prev) | (fall_q & ~lvl_sync & lvl_prev);
  assign stat_wr   = wr_en && (wr_cls == CLS_STAT);
  assign clr_mask  = stat_wr ? wdata : '0;
  // a fresh edge outranks a clear of the same bit
  assign stat_next = (stat_q & ~clr_mask) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_next;
      if (wr_en) begin
        case (wr_cls)
          CLS_DIR:  dir_q  <= wdata;
          CLS_SET:  out_q  <= out_q | wdata;
          CLS_CLR:  out_q  <= out_q & ~wdata;
          CLS_RISE: rise_q <= wdata;
          CLS_FALL: fall_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && hits == '0) |=> (stat_q == ($past(stat_q) & ~$past(wdata)))); // R9
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (hits != '0) |=> ((stat_q & $past(hits)) == $past(hits))); // R10
  AST_SET_OUT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_cls == CLS_SET) |=> ((out_q & $past(wdata)) == $past(wdata))); // R4
  AST_CLR_OUT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_cls == CLS_CLR) |=> ((out_q & $past(wdata)) == '0)); // R4
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [5:0]          bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int NUM_BANKS = NUM_PINS / WORD_W;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CLS_W     = 3;

  logic [WORD_W-1:0] sync_b [NUM_BANKS];
  logic [WORD_W-1:0] prev_b [NUM_BANKS];
  logic [WORD_W-1:0] dir_b  [NUM_BANKS];
  logic [WORD_W-1:0] out_b  [NUM_BANKS];
  logic [WORD_W-1:0] rise_b [NUM_BANKS];
  logic [WORD_W-1:0] fall_b [NUM_BANKS];
  logic [WORD_W-1:0] stat_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_any;

  reg_cls_e          sel_cls;
  logic [BANK_W-1:0] sel_bank;
  logic              any_stat;
  logic [WORD_W-1:0] rd_word;

  assign sel_bank = bus_addr[2 +: BANK_W];
  assign sel_cls  = reg_cls_e'(bus_addr[2 + BANK_W +: CLS_W]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_valid && bus_write && (sel_bank == BANK_W'(b));

    gpio_pin_sync #(.WIDTH(WORD_W)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .pin_async (pin_in[b*WORD_W +: WORD_W]),
      .lvl_sync  (sync_b[b]),
      .lvl_prev  (prev_b[b])
    );

    gpio_edge_bank #(.WIDTH(WORD_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bank_wr),
      .wr_cls   (sel_cls),
      .wdata    (bus_wdata),
      .lvl_sync (sync_b[b]),
      .lvl_prev (prev_b[b]),
      .dir_q    (dir_b[b]),
      .out_q    (out_b[b]),
      .rise_q   (rise_b[b]),
      .fall_q   (fall_b[b]),
      .stat_q   (stat_b[b])
    );

    assign pin_out[b*WORD_W +: WORD_W] = out_b[b];
    assign pin_oe[b*WORD_W +: WORD_W]  = dir_b[b];
    assign bank_any[b] = |stat_b[b];
  end

  assign any_stat = |bank_any;

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_bank == BANK_W'(b)) begin
        case (sel_cls)
          CLS_LEVEL: rd_word = sync_b[b];
          CLS_DIR:   rd_word = dir_b[b];
          CLS_RISE:  rd_word = rise_b[b];
          CLS_FALL:  rd_word = fall_b[b];
          CLS_STAT:  rd_word = stat_b[b];
          default:   rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_word;
      irq <= any_stat;
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    any_stat |=> irq); // R11
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    !any_stat |=> !irq); // R11
  AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid); // R12
  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid); // R12
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (sel_cls == CLS_SET || sel_cls == CLS_CLR))
      |=> (bus_rdata == '0)); // R4
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_data[$];
  string       exp_tag[$];

  always #5 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // address of class c, bank b (R2)
  function automatic logic [5:0] wa(int c, int b);
    return 6'(c * 8 + b * 4);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int c, int b, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = wa(c, b); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // driver: queues expected read data, then issues the request
  task automatic rd(int c, int b, logic [31:0] exp, string tag);
    exp_data.push_back(exp);
    exp_tag.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = wa(c, b);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops and compares every returned read (R12)
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_data.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12 unexpected rvalid actual=%h expected=none", bus_rdata);
      end else begin
        check(exp_tag.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_data.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ticks(1);
    ticks(3);
    rst = 1'b0;
    ticks(1);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 64'h0);
    check("R1 pin_out", pin_out, 64'h0);
    check("R1 irq", {63'h0, irq}, 64'h0);
    rd(1, 0, 32'h0, "R1 dir0");
    rd(4, 1, 32'h0, "R1 rise1");
    rd(6, 0, 32'h0, "R1 stat0");

    // R3 / R2 direction on bank 1
    wr(1, 1, 32'hF0F0_0001);
    check("R3 pin_oe", pin_oe, 64'hF0F0_0001_0000_0000);
    rd(1, 1, 32'hF0F0_0001, "R3 dir1 readback");
    rd(1, 0, 32'h0, "R2 dir0 untouched");

    // R4 set / clear
    wr(2, 0, 32'h0000_00FF);
    wr(2, 0, 32'h0000_0100);
    check("R4 set", pin_out, 64'h0000_0000_0000_01FF);
    wr(3, 0, 32'h0000_000F);
    check("R4 clear", pin_out, 64'h0000_0000_0000_01F0);
    wr(2, 1, 32'h8000_0000);
    check("R4 set bank1", pin_out, 64'h8000_0000_0000_01F0);
    rd(2, 0, 32'h0, "R4 set word reads 0");
    rd(3, 1, 32'h0, "R4 clr word reads 0");

    // R5 level through synchroniser
    pin_in = 64'h1234_5678_A5A5_5A5A;
    ticks(1);
    rd(0, 0, 32'h0, "R5 level not yet synced");
    ticks(2);
    rd(0, 0, 32'hA5A5_5A5A, "R5 level bank0");
    rd(0, 1, 32'h1234_5678, "R5 level bank1");
    pin_in = '0;
    ticks(4);
    rd(6, 0, 32'h0, "R6 no enable no status");
    rd(6, 1, 32'h0, "R6 no enable no status b1");

    // R6 rising on pin 3
    wr(4, 0, 32'h0000_0008);
    rd(4, 0, 32'h0000_0008, "R6 rise enable readback");
    pin_in[3] = 1'b1;
    ticks(4);
    check("R11 irq after rise", {63'h0, irq}, 64'h1);
    rd(6, 0, 32'h0000_0008, "R6 rising sets status");
    pin_in[3] = 1'b0;
    ticks(4);
    rd(6, 0, 32'h0000_0008, "R6 falling ignored with rise only");
    wr(6, 0, 32'hFFFF_FFF7);
    rd(6, 0, 32'h0000_0008, "R9 zero write keeps bit");
    wr(6, 0, 32'h0000_0008);
    rd(6, 0, 32'h0, "R9 one write clears");
    check("R11 irq low", {63'h0, irq}, 64'h0);

    // R7 falling on pin 37 (bank1 bit5)
    wr(5, 1, 32'h0000_0020);
    pin_in[37] = 1'b1;
    ticks(4);
    rd(6, 1, 32'h0, "R7 rise ignored with fall only");
    pin_in[37] = 1'b0;
    ticks(4);
    rd(6, 1, 32'h0000_0020, "R7 falling sets status");
    check("R11 irq bank1", {63'h0, irq}, 64'h1);
    wr(6, 1, 32'h0000_0020);
    ticks(1);
    check("R11 irq cleared", {63'h0, irq}, 64'h0);

    // R8 both edges on pin 10; pin 11 unarmed
    wr(4, 0, 32'h0000_0400);
    wr(5, 0, 32'h0000_0400);
    pin_in[10] = 1'b1; pin_in[11] = 1'b1;
    ticks(4);
    rd(6, 0, 32'h0000_0400, "R8 rise with both");
    wr(6, 0, 32'h0000_0400);
    pin_in[10] = 1'b0; pin_in[11] = 1'b0;
    ticks(4);
    rd(6, 0, 32'h0000_0400, "R8 fall with both");

    // R10 edge and clear in the same cycle
    pin_in[10] = 1'b1;
    ticks(2);
    wr(6, 0, 32'h0000_0400);
    ticks(2);
    rd(6, 0, 32'h0000_0400, "R10 edge beats clear");
    check("R10 irq stays", {63'h0, irq}, 64'h1);
    wr(6, 0, 32'h0000_0400);
    ticks(1);
    rd(6, 0, 32'h0, "R10 later clear works");
    check("R11 irq final", {63'h0, irq}, 64'h0);

    ticks(3);
    check("R12 queue drained", 64'(exp_data.size()), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule